// File: doc/BRIEF.md
# Edge-to-Edge Timing Bit Checker

This block decides whether a demodulated bit stream looks like a genuine transmission or like noise. It does so by timing the gap between successive transitions of the stream. Each gap is measured in ticks of an external timebase and must fall inside a programmable window. A programmed number of consecutive in-window gaps ends the check with a one-cycle pass pulse. The first gap outside the window ends it at once with a one-cycle fail pulse.

A polling controller raises the enable when it wants a check. The first transition after enable only starts the timing and is not judged. After a pass or a fail the block stays silent until the enable is dropped and raised again. The raw stream is brought into the clock domain through a two-flop synchronizer before transitions are detected. A lower bound programmed below 10 is treated as 10.

Top module: `edge_window_checker`

## Requirements
- R1: After reset, and while the enable is low, both `pass_o` and `fail_o` are 0.
- R2: `data_i` passes two synchronizer flops. For the transition that completes a check, the pulse is high in the cycle after the third rising clock edge that follows the change of `data_i`, and it lasts exactly one cycle.
- R3: The first transition after enable starts timing and is not judged. Any number of ticks before that transition causes no fail.
- R4: An interval of L ticks ending in a transition is good if eff_lo <= L < `lim_hi_i`, where eff_lo is the effective lower bound. A transition with L < eff_lo gives a fail.
- R5: When the hi-th tick (hi = `lim_hi_i`) of an interval arrives without a transition, `fail_o` pulses on that tick and does not wait for a transition.
- R6: eff_lo equals `lim_lo_i` when `lim_lo_i` >= 10, and equals 10 otherwise.
- R7: `pass_o` pulses on the transition that completes `need_i` consecutive good intervals. A `need_i` of 0 behaves as 1. No pulse occurs before that transition.
- R8: After a pass or a fail the block ignores all transitions and ticks, and emits no pulse, until the enable goes low and then high again.
- R9: While `en_i` is low, transitions and ticks are ignored, and timing restarts from the waiting-for-first-transition state on the next enable.
- R10: If a tick and a detected transition fall in the same cycle, the transition wins and that tick is not counted in the closing interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the check while high; low clears it |
| data_i | input | 1 | Demodulated bit stream, asynchronous |
| tick_i | input | 1 | One-cycle timebase strobe |
| lim_lo_i | input | 6 | Lower window bound in ticks |
| lim_hi_i | input | 6 | Upper window bound in ticks, exclusive |
| need_i | input | 4 | Good intervals required for a pass |
| pass_o | output | 1 | One-cycle pulse: stream accepted |
| fail_o | output | 1 | One-cycle pulse: stream rejected |

## Verification
A wrong interval count or wrong bound shows up as a pass where a fail belongs, or the reverse. It appears on the very transition or tick that closes the affected interval, so a sweep of every interval length against several windows catches an off-by-one at the boundary it belongs to. A wrong count of good intervals shows as an early or missing pass within at most `need_i` intervals. A control state that fails to idle shows as a second pulse on the next interval after a decision.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAIT,
    ST_TIME,
    ST_DONE
  } ewc_state_e;
endpackage

// File: rtl/ewc_edge_sync.sv
module ewc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= data_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];

  assign edge_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/ewc_interval.sv
module ewc_interval #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                              cnt_q <= '0;
    else if (clear_i)                         cnt_q <= '0;
    else if (run_i && tick_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ewc_judge.sv
module ewc_judge
  import ewc_pkg::*;
#(
  parameter int LIM_W     = 6,
  parameter int NEED_W    = 4,
  parameter int LIM_FLOOR = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              edge_i,
  input  logic              tick_i,
  input  logic [LIM_W-1:0]  cnt_i,
  input  logic [LIM_W-1:0]  lim_lo_i,
  input  logic [LIM_W-1:0]  lim_hi_i,
  input  logic [NEED_W-1:0] need_i,
  output logic              clear_o,
  output logic              run_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam logic [LIM_W-1:0] FLOOR = LIM_W'(LIM_FLOOR);

  ewc_state_e        state_q;
  logic [NEED_W-1:0] good_q;
  logic              pass_q, fail_q;

  logic [LIM_W-1:0]  lo_eff;
  logic [LIM_W:0]    cnt_inc;
  logic [NEED_W:0]   good_inc;
  logic              too_short, reach_hi, enough;

  assign lo_eff    = (lim_lo_i < FLOOR) ? FLOOR : lim_lo_i;
  assign too_short = cnt_i < lo_eff;
  assign cnt_inc   = {1'b0, cnt_i} + 1'b1;
  assign reach_hi  = cnt_inc >= {1'b0, lim_hi_i};
  assign good_inc  = {1'b0, good_q} + 1'b1;
  assign enough    = good_inc >= {1'b0, need_i};

  // edge has priority: it clears the counter even when a tick coincides
  assign run_o   = state_q == ST_TIME;
  assign clear_o = !run_o || edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      good_q  <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_OFF;
        good_q  <= '0;
      end else begin
        unique case (state_q)
          ST_OFF:  state_q <= ST_WAIT;
          ST_WAIT: if (edge_i) begin
            state_q <= ST_TIME;
            good_q  <= '0;
          end
          ST_TIME: begin
            if (edge_i) begin
              if (too_short) begin
                fail_q  <= 1'b1;
                state_q <= ST_DONE;
              end else if (enough) begin
                pass_q  <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                good_q <= good_inc[NEED_W-1:0];
              end
            end else if (tick_i && reach_hi) begin
              fail_q  <= 1'b1;
              state_q <= ST_DONE;
            end
          end
          default: state_q <= ST_DONE;
        endcase
      end
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;

  AST_PASS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o); // R8
  AST_FAIL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o); // R8
  AST_DONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && $past(state_q) == ST_DONE) |-> !(pass_o || fail_o)); // R8
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(pass_o || fail_o)); // R9
  AST_PASS_FROM_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(state_q) == ST_TIME && $past(edge_i)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TIME && $past(state_q) == ST_TIME && $stable(lim_hi_i))
      |-> cnt_i <= lim_hi_i); // R5
endmodule

// File: rtl/edge_window_checker.sv
module edge_window_checker #(
  parameter int LIM_W       = 6,
  parameter int NEED_W      = 4,
  parameter int LIM_FLOOR   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              data_i,
  input  logic              tick_i,
  input  logic [LIM_W-1:0]  lim_lo_i,
  input  logic [LIM_W-1:0]  lim_hi_i,
  input  logic [NEED_W-1:0] need_i,
  output logic              pass_o,
  output logic              fail_o
);
  logic             edge_w, clear_w, run_w;
  logic [LIM_W-1:0] cnt_w;

  ewc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .edge_o (edge_w)
  );

  ewc_interval #(.W(LIM_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_w),
    .run_i   (run_w),
    .tick_i  (tick_i),
    .cnt_o   (cnt_w)
  );

  ewc_judge #(
    .LIM_W     (LIM_W),
    .NEED_W    (NEED_W),
    .LIM_FLOOR (LIM_FLOOR)
  ) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .edge_i   (edge_w),
    .tick_i   (tick_i),
    .cnt_i    (cnt_w),
    .lim_lo_i (lim_lo_i),
    .lim_hi_i (lim_hi_i),
    .need_i   (need_i),
    .clear_o  (clear_w),
    .run_o    (run_w),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
  );

  AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o)); // R7
endmodule

// File: tb/edge_window_checker_test.sv
module edge_window_checker_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       data = 1'b0;
  logic       tick = 1'b0;
  logic [5:0] lim_lo = 6'd10;
  logic [5:0] lim_hi = 6'd16;
  logic [3:0] need = 4'd1;
  logic       pass, fail;

  int total = 0;
  int bad = 0;
  int npass = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_window_checker uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .data_i   (data),
    .tick_i   (tick),
    .lim_lo_i (lim_lo),
    .lim_hi_i (lim_hi),
    .need_i   (need),
    .pass_o   (pass),
    .fail_o   (fail)
  );

  always @(negedge clk) begin
    if (pass) npass++;
    if (fail) nfail++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle();
    data = ~data;
    step(4);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step(1);
      tick = 1'b0;
      step(1);
    end
  endtask

  task automatic start(input int lo, input int hi, input int nd);
    en = 1'b0;
    step(2);
    lim_lo = 6'(lo);
    lim_hi = 6'(hi);
    need   = 4'(nd);
    npass = 0;
    nfail = 0;
    en = 1'b1;
    step(2);
    toggle(); // first edge only starts timing
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lo_set[5] = '{0, 9, 10, 12, 15};
    int hi_set[3] = '{11, 14, 20};

    step(3);
    chk("R1 reset pass", int'(pass), 0);
    chk("R1 reset fail", int'(fail), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 idle pass", npass, 0);
    chk("R1 idle fail", nfail, 0);

    // R4 R5 R6: every interval length against several windows
    foreach (lo_set[a]) begin
      foreach (hi_set[b]) begin
        for (int len = 0; len <= hi_set[b] + 1; len++) begin
          int eff;
          bit good;
          eff  = (lo_set[a] < 10) ? 10 : lo_set[a];
          good = (len >= eff) && (len < hi_set[b]);
          start(lo_set[a], hi_set[b], 1);
          ticks(len);
          toggle();
          step(2);
          if (len >= hi_set[b]) begin
            chk("R5 window top pass", npass, 0);
            chk("R5 window top fail", nfail, 1);
          end else if (lo_set[a] < 10) begin
            chk("R6 clamp pass", npass, good ? 1 : 0);
            chk("R6 clamp fail", nfail, good ? 0 : 1);
          end else begin
            chk("R4 window pass", npass, good ? 1 : 0);
            chk("R4 window fail", nfail, good ? 0 : 1);
          end
        end
      end
    end

    // R5: fail fires on the hi-th tick, before any edge
    start(10, 15, 1);
    ticks(14);
    chk("R5 before top", nfail, 0);
    ticks(1);
    chk("R5 at top", nfail, 1);

    // R3: ticks before the first edge are not judged
    en = 1'b0;
    step(2);
    lim_lo = 6'd10; lim_hi = 6'd16; need = 4'd1;
    npass = 0; nfail = 0;
    en = 1'b1;
    step(2);
    ticks(70);
    chk("R3 no fail before first edge", nfail, 0);
    toggle();
    chk("R3 first edge not judged", nfail + npass, 0);
    ticks(12);
    toggle();
    chk("R3 pass after first interval", npass, 1);

    // R7: consecutive good intervals, need from 0 to 6
    for (int nd = 0; nd <= 6; nd++) begin
      int req_n;
      req_n = (nd == 0) ? 1 : nd;
      start(10, 16, nd);
      for (int k = 1; k <= req_n; k++) begin
        ticks(12);
        toggle();
        chk("R7 pass count", npass, (k >= req_n) ? 1 : 0);
      end
      chk("R7 no fail", nfail, 0);
    end

    // R7: a bad interval after good ones aborts
    start(10, 16, 3);
    ticks(11); toggle();
    ticks(13); toggle();
    ticks(3);  toggle();
    chk("R7 abort pass", npass, 0);
    chk("R7 abort fail", nfail, 1);

    // R8: idle after a decision until re-enabled
    start(10, 16, 1);
    ticks(12); toggle();
    ticks(2);  toggle();
    ticks(30); toggle();
    ticks(12); toggle();
    chk("R8 pass once", npass, 1);
    chk("R8 no later fail", nfail, 0);
    start(10, 16, 1);
    ticks(4); toggle();
    chk("R8 re-enabled fail", nfail, 1);
    chk("R8 re-enabled pass", npass, 0);

    // R9: inputs ignored while disabled, fresh start on enable
    en = 1'b0;
    npass = 0; nfail = 0;
    step(2);
    for (int k = 0; k < 6; k++) begin
      ticks(20);
      toggle();
    end
    chk("R9 disabled quiet", npass + nfail, 0);
    en = 1'b1;
    step(2);
    ticks(40);
    chk("R9 restart waits for edge", nfail, 0);
    toggle();
    ticks(10); toggle();
    chk("R9 restart pass", npass, 1);

    // R10: tick in the edge cycle is not counted
    start(10, 16, 1);
    ticks(15);
    data = ~data;
    step(2);
    tick = 1'b1;
    step(1);
    tick = 1'b0;
    step(2);
    chk("R10 edge wins pass", npass, 1);
    chk("R10 edge wins fail", nfail, 0);

    // R2: latency and width of the decision pulse
    start(10, 16, 1);
    ticks(12);
    data = ~data;
    step(1);
    chk("R2 after edge 1", int'(pass), 0);
    step(1);
    chk("R2 after edge 2", int'(pass), 0);
    step(1);
    chk("R2 after edge 3", int'(pass), 1);
    step(1);
    chk("R2 one cycle", int'(pass), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule